// File: doc/BRIEF.md
# Multi-Stream Rate Governor Calculator

This block is a sequential fixed-point arithmetic unit that works out the per-stream rate-governor parameters for one stream carried over a multi-stream transport link. A stream is described by its pixel clock, its bits per pixel (or a compressed bits-per-pixel value when compression is on), and its bandwidth allocation number. The link is described by its rate and lane count. Two optional overhead multipliers can also be applied: one for compression and one for forward error correction.

Internally the unit computes two estimates of time slots per symbol period. One is a lower bound taken from the stream's actual bandwidth. The other is an upper bound taken from the bandwidth allocation. It averages the two and scales the mean by any non-zero overhead factor. It then expresses the result as symbols per lane group: an integer part, plus a fraction counted in 1/256 steps and rounded up. All arithmetic is unsigned, with 32 fractional bits. One iterative divider and one iterative multiplier carry the work, so a result takes a few hundred cycles.

A controller pulses `start` with the operands valid. It waits for the one-cycle `done` pulse and then reads `x_int` and `y_frac`. These stay unchanged until the next result.

Top module: `rate_gov`

## Requirements
- R1: The lower slot estimate is floor(pix_clk_khz * b * 64 * 2^32 / (link_rate * lane_cnt * 8)), where b is the effective bits per pixel.
- R2: The upper slot estimate is floor(pbn * 54000 * 2^32 / (link_rate * lane_cnt)).
- R3: The raw target is floor((lower + upper) / 2), held as a 64-bit value with 32 fractional bits.
- R4: dsc_ovh and fec_ovh are unsigned factors with 2 integer and 32 fractional bits. A non-zero dsc_ovh multiplies the raw target first, and a non-zero fec_ovh multiplies the result after that. Each product keeps bits [95:32]. A zero factor leaves the target unchanged.
- R5: When cmp_en is 1 the effective bits per pixel is cmp_bpp; when cmp_en is 0 it is bpp.
- R6: The target is split into its integer part I (bits [63:32]) and an enumerator E = floor(F * 256 * lane_cnt / 2^32), where F is bits [31:0]. The per-lane-group value is S = (I * 2^32 + floor(E * 2^32 / (256 * lane_cnt))) * lane_cnt.
- R7: x_int equals floor(S / 2^32).
- R8: y_frac equals ceil((S mod 2^32) * 256 / 2^32), a value from 0 to 256.
- R9: done is high for exactly one cycle per accepted start, and busy is low in that cycle. busy goes high in the cycle after an accepted start.
- R10: Operands are captured when start is accepted. x_int and y_frac change only in the cycle done is high, and hold even if the inputs change afterwards.
- R11: start while busy is high is ignored: the running computation finishes with its original operands.
- R12: After reset, busy, done, x_int and y_frac are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| pix_clk_khz | input | PCLK_W | Pixel clock in kHz |
| link_rate | input | LCLK_W | Per-lane link rate value |
| lane_cnt | input | LANE_W | Active lane count (1, 2 or 4) |
| bpp | input | BPP_W | Uncompressed bits per pixel |
| cmp_en | input | 1 | Use cmp_bpp instead of bpp |
| cmp_bpp | input | BPP_W | Compressed bits per pixel |
| pbn | input | PBN_W | Bandwidth allocation number |
| dsc_ovh | input | OVH_W | Compression overhead factor, 2.32 format, 0 = none |
| fec_ovh | input | OVH_W | Error-correction overhead factor, 2.32 format, 0 = none |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| x_int | output | 32+LANE_W | Integer symbols per lane group |
| y_frac | output | 9 | Fraction in 1/256 units, rounded up |

## Verification
The assertions take `start` to be a synchronous level. They also take `link_rate` and `lane_cnt` to be non-zero whenever a start is accepted, so that no divisor is zero, and the operand widths to be small enough that the lower-estimate dividend fits in 64 bits. The sweep respects these limits. It uses lane counts of 1, 2 and 4, three realistic link rates, and pixel clocks and allocation numbers of display scale. It covers every on/off combination of the two overhead factors, with and without compression. Two directed cases cover the other handshake rules: a start issued mid-run, and input changes after a result.

// File: rtl/rate_gov_pkg.sv
// Package: shared constants and the sequencer state type for the rate governor.
// Assumes the fixed-point format is unsigned with FRAC_BITS fractional bits.
package rate_gov_pkg;
    localparam int FRAC_BITS = 32;
    localparam int ACC_BITS  = 64;
    localparam int SLOT_MUL  = 54000;

    typedef enum logic [2:0] {
        GS_IDLE,
        GS_LOWER,
        GS_UPPER,
        GS_OVH_A,
        GS_OVH_B,
        GS_FRAC
    } gov_state_t;
endpackage

// File: rtl/gov_div.sv
// Module: gov_div - restoring unsigned divider, one quotient bit per cycle.
// Operands are captured on start. The quotient is valid while done is high and
// stays valid until the next start. Assumes a non-zero divisor.
module gov_div #(
    parameter int DVD_W = 64,
    parameter int DVS_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [DVD_W-1:0] quot
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] dvd_q;
    logic [DVS_W-1:0] dvs_q;
    logic [DVS_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DVS_W:0]   trial;
    logic [DVS_W:0]   diff;
    logic             take;

    // Trial subtraction for the current quotient bit.
    always_comb begin
        trial = {rem_q, dvd_q[DVD_W-1]};
        take  = (trial >= {1'b0, dvs_q});
        diff  = trial - {1'b0, dvs_q};
    end

    // Load the operands, then shift one quotient bit into the dividend register per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dvs_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dvd_q <= dividend;
                dvs_q <= divisor;
                rem_q <= '0;
                cnt_q <= CNT_W'(DVD_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                dvd_q <= {dvd_q[DVD_W-2:0], take};
                rem_q <= take ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quot = dvd_q;
endmodule

// File: rtl/gov_mul.sv
// Module: gov_mul - shift-and-add unsigned multiplier, one multiplier bit per cycle.
// Operands are captured on start. The full product is valid while done is high
// and stays valid until the next start.
module gov_mul #(
    parameter int A_W = 64,
    parameter int B_W = 34
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    output logic               done,
    output logic [A_W+B_W-1:0] prod
);
    localparam int P_W   = A_W + B_W;
    localparam int CNT_W = $clog2(B_W + 1);

    logic [P_W-1:0]   acc_q;
    logic [P_W-1:0]   mc_q;
    logic [B_W-1:0]   mp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Add the shifted multiplicand for each set multiplier bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            mc_q  <= '0;
            mp_q  <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc_q <= '0;
                mc_q  <= P_W'(a);
                mp_q  <= b;
                cnt_q <= CNT_W'(B_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (mp_q[0]) begin
                    acc_q <= acc_q + mc_q;
                end
                mc_q  <= mc_q << 1;
                mp_q  <= mp_q >> 1;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign prod = acc_q;
endmodule

// File: rtl/rate_gov.sv
// Module: rate_gov - sequencer for the multi-stream rate-governor calculation.
// The steps run in this order: lower slot estimate, upper slot estimate, mean,
// optional compression overhead, optional error-correction overhead, then the
// lane-scaled integer and fraction. Assumes link_rate and lane_cnt are non-zero
// and that pix_clk_khz*bpp*64 fits in 32 bits.
module rate_gov
    import rate_gov_pkg::*;
#(
    parameter int PCLK_W = 20,
    parameter int LCLK_W = 20,
    parameter int LANE_W = 3,
    parameter int BPP_W  = 6,
    parameter int PBN_W  = 12,
    parameter int OVH_W  = 34
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [PCLK_W-1:0]        pix_clk_khz,
    input  logic [LCLK_W-1:0]        link_rate,
    input  logic [LANE_W-1:0]        lane_cnt,
    input  logic [BPP_W-1:0]         bpp,
    input  logic                     cmp_en,
    input  logic [BPP_W-1:0]         cmp_bpp,
    input  logic [PBN_W-1:0]         pbn,
    input  logic [OVH_W-1:0]         dsc_ovh,
    input  logic [OVH_W-1:0]         fec_ovh,
    output logic                     busy,
    output logic                     done,
    output logic [FRAC_BITS+LANE_W-1:0] x_int,
    output logic [8:0]               y_frac
);
    localparam int FB     = FRAC_BITS;
    localparam int AW     = ACC_BITS;
    localparam int ENUM_W = LANE_W + 8;
    localparam int DEN_A  = LCLK_W + LANE_W + 3;
    localparam int DVS_W  = (DEN_A > ENUM_W) ? DEN_A : ENUM_W;
    localparam int SYM_W  = AW + LANE_W;
    localparam int P_W    = AW + OVH_W;

    gov_state_t state_q;

    logic [PCLK_W-1:0] pclk_q;
    logic [LCLK_W-1:0] lclk_q;
    logic [LANE_W-1:0] lanes_q;
    logic [BPP_W-1:0]  bpp_q;
    logic [PBN_W-1:0]  pbn_q;
    logic [OVH_W-1:0]  ovh_a_q;
    logic [OVH_W-1:0]  ovh_b_q;
    logic [AW-1:0]     lower_q;
    logic [AW-1:0]     raw_q;
    logic              div_go;
    logic              mul_go;

    logic [AW-1:0]     div_dvd;
    logic [DVS_W-1:0]  div_dvs;
    logic              div_done;
    logic [AW-1:0]     div_quot;
    logic [OVH_W-1:0]  mul_b;
    logic              mul_done;
    logic [P_W-1:0]    mul_prod;

    logic [AW:0]          mean_sum;
    logic [ENUM_W-1:0]    lane_scale;
    logic [FB+ENUM_W-1:0] frac_prod;
    logic [ENUM_W-1:0]    ts_enum;
    logic [AW-1:0]        base_fix;
    logic [SYM_W-1:0]     sym;
    logic [FB+7:0]        y_prod;

    // Operand selection for the shared divider, by sequencer step.
    always_comb begin
        case (state_q)
            GS_LOWER: begin
                div_dvd = (AW'(pclk_q) * AW'(bpp_q)) << (FB + 6);
                div_dvs = (DVS_W'(lclk_q) * DVS_W'(lanes_q)) << 3;
            end
            GS_UPPER: begin
                div_dvd = (AW'(pbn_q) * AW'(SLOT_MUL)) << FB;
                div_dvs = DVS_W'(lclk_q) * DVS_W'(lanes_q);
            end
            GS_FRAC: begin
                div_dvd = AW'(ts_enum) << FB;
                div_dvs = DVS_W'(lane_scale);
            end
            default: begin
                div_dvd = '0;
                div_dvs = DVS_W'(1);
            end
        endcase
    end

    // Overhead factor selection for the shared multiplier.
    assign mul_b = (state_q == GS_OVH_A) ? ovh_a_q : ovh_b_q;

    // Mean of the two estimates, and the fraction enumerator over 256 * lanes.
    always_comb begin
        mean_sum   = {1'b0, lower_q} + {1'b0, div_quot};
        lane_scale = {lanes_q, 8'h00};
        frac_prod  = (FB+ENUM_W)'(raw_q[FB-1:0]) * (FB+ENUM_W)'(lane_scale);
        ts_enum    = frac_prod[FB+ENUM_W-1:FB];
    end

    // Recombine the integer and the re-divided fraction, scale by lanes, and round the fraction up.
    always_comb begin
        base_fix = {raw_q[AW-1:FB], {FB{1'b0}}} + div_quot;
        sym      = SYM_W'(base_fix) * SYM_W'(lanes_q);
        y_prod   = {sym[FB-1:0], 8'h00};
    end

    gov_div #(.DVD_W(AW), .DVS_W(DVS_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_go),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .done     (div_done),
        .quot     (div_quot)
    );

    gov_mul #(.A_W(AW), .B_W(OVH_W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_go),
        .a     (raw_q),
        .b     (mul_b),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    // Sequencer: capture the operands, step through each stage, publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            pclk_q  <= '0;
            lclk_q  <= '0;
            lanes_q <= '0;
            bpp_q   <= '0;
            pbn_q   <= '0;
            ovh_a_q <= '0;
            ovh_b_q <= '0;
            lower_q <= '0;
            raw_q   <= '0;
            div_go  <= 1'b0;
            mul_go  <= 1'b0;
            done    <= 1'b0;
            x_int   <= '0;
            y_frac  <= '0;
        end else begin
            done   <= 1'b0;
            div_go <= 1'b0;
            mul_go <= 1'b0;
            case (state_q)
                GS_IDLE: begin
                    if (start) begin
                        pclk_q  <= pix_clk_khz;
                        lclk_q  <= link_rate;
                        lanes_q <= lane_cnt;
                        bpp_q   <= cmp_en ? cmp_bpp : bpp;
                        pbn_q   <= pbn;
                        ovh_a_q <= dsc_ovh;
                        ovh_b_q <= fec_ovh;
                        div_go  <= 1'b1;
                        state_q <= GS_LOWER;
                    end
                end
                GS_LOWER: begin
                    if (div_done) begin
                        lower_q <= div_quot;
                        div_go  <= 1'b1;
                        state_q <= GS_UPPER;
                    end
                end
                GS_UPPER: begin
                    if (div_done) begin
                        raw_q <= mean_sum[AW:1];
                        if (ovh_a_q != '0) begin
                            mul_go  <= 1'b1;
                            state_q <= GS_OVH_A;
                        end else if (ovh_b_q != '0) begin
                            mul_go  <= 1'b1;
                            state_q <= GS_OVH_B;
                        end else begin
                            div_go  <= 1'b1;
                            state_q <= GS_FRAC;
                        end
                    end
                end
                GS_OVH_A: begin
                    if (mul_done) begin
                        raw_q <= mul_prod[FB+AW-1:FB];
                        if (ovh_b_q != '0) begin
                            mul_go  <= 1'b1;
                            state_q <= GS_OVH_B;
                        end else begin
                            div_go  <= 1'b1;
                            state_q <= GS_FRAC;
                        end
                    end
                end
                GS_OVH_B: begin
                    if (mul_done) begin
                        raw_q   <= mul_prod[FB+AW-1:FB];
                        div_go  <= 1'b1;
                        state_q <= GS_FRAC;
                    end
                end
                GS_FRAC: begin
                    if (div_done) begin
                        x_int   <= sym[SYM_W-1:FB];
                        y_frac  <= {1'b0, y_prod[FB+7:FB]} + 9'(|y_prod[FB-1:0]);
                        done    <= 1'b1;
                        state_q <= GS_IDLE;
                    end
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end

    assign busy = (state_q != GS_IDLE);
endmodule

// File: rtl/rate_gov_chk.sv
// Module: rate_gov_chk - handshake and hold properties of rate_gov, bound to the top.
// Assumes the default LANE_W, which sets the x_int width.
module rate_gov_chk #(
    parameter int XW = 35
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [XW-1:0] x_int,
    input logic [8:0]    y_frac
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R11
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(x_int) && $stable(y_frac)));

    // R8
    frac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (y_frac <= 9'd256));
endmodule

bind rate_gov rate_gov_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .x_int  (x_int),
    .y_frac (y_frac)
);

// File: tb/sim_rate_gov.sv
// Bench: sweeps lane count, link rate, pixel clock, allocation number,
// compression and both overhead factors, and compares each result with an
// arithmetic model of the requirements.
module sim_rate_gov;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] pix_clk_khz = '0;
    logic [19:0] link_rate = '0;
    logic [2:0]  lane_cnt = '0;
    logic [5:0]  bpp = '0;
    logic        cmp_en = 1'b0;
    logic [5:0]  cmp_bpp = '0;
    logic [11:0] pbn = '0;
    logic [33:0] dsc_ovh = '0;
    logic [33:0] fec_ovh = '0;
    logic        busy;
    logic        done;
    logic [34:0] x_int;
    logic [8:0]  y_frac;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rate_gov u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pix_clk_khz(pix_clk_khz), .link_rate(link_rate), .lane_cnt(lane_cnt),
        .bpp(bpp), .cmp_en(cmp_en), .cmp_bpp(cmp_bpp), .pbn(pbn),
        .dsc_ovh(dsc_ovh), .fec_ovh(fec_ovh),
        .busy(busy), .done(done), .x_int(x_int), .y_frac(y_frac)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Model of R1..R8 in wide arithmetic.
    task automatic model(input logic [19:0] pc, input logic [19:0] lr, input logic [2:0] ln,
                         input logic [5:0] b, input logic ce, input logic [5:0] cb,
                         input logic [11:0] pn, input logic [33:0] da, input logic [33:0] fa,
                         output logic [34:0] xo, output logic [8:0] yo);
        logic [127:0] eb, lo, up, raw, ti, fr, te, q, sym, t;
        logic [127:0] m32;
        m32 = 128'hFFFF_FFFF;
        eb  = ce ? 128'(cb) : 128'(b);                                        // R5
        lo  = ((128'(pc) * eb * 64) << 32) / (128'(lr) * 128'(ln) * 8);       // R1
        up  = ((128'(pn) * 54000) << 32) / (128'(lr) * 128'(ln));             // R2
        raw = (lo + up) >> 1;                                                  // R3
        if (da != 0) raw = ((raw * 128'(da)) >> 32) & {64'h0, {64{1'b1}}};    // R4
        if (fa != 0) raw = ((raw * 128'(fa)) >> 32) & {64'h0, {64{1'b1}}};
        ti  = raw >> 32;                                                       // R6
        fr  = raw & m32;
        te  = (fr * 128'(ln) * 256) >> 32;
        q   = (te << 32) / (128'(ln) * 256);
        sym = ((ti << 32) + q) * 128'(ln);
        xo  = 35'(sym >> 32);                                                  // R7
        t   = (sym & m32) * 256;
        yo  = 9'((t >> 32) + ((t & m32) != 0 ? 128'd1 : 128'd0));             // R8
    endtask

    task automatic drive(input logic [19:0] pc, input logic [19:0] lr, input logic [2:0] ln,
                         input logic ce, input logic [11:0] pn, input logic [33:0] da,
                         input logic [33:0] fa);
        pix_clk_khz = pc; link_rate = lr; lane_cnt = ln; bpp = 6'd24;
        cmp_en = ce; cmp_bpp = 6'd8; pbn = pn; dsc_ovh = da; fec_ovh = fa;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (done) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_one(input logic [19:0] pc, input logic [19:0] lr, input logic [2:0] ln,
                           input logic ce, input logic [11:0] pn, input logic [33:0] da,
                           input logic [33:0] fa);
        logic [34:0] ex;
        logic [8:0]  ey;
        bit got;
        model(pc, lr, ln, 6'd24, ce, 6'd8, pn, da, fa, ex, ey);
        drive(pc, lr, ln, ce, pn, da, fa);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", longint'(busy), 1);
        wait_done(got);
        chk(got, "R9 done seen", longint'(got), 1);
        chk(x_int == ex, "R1/R2/R3/R4/R5/R6/R7 x_int", longint'(x_int), longint'(ex));
        chk(y_frac == ey, "R8 y_frac", longint'(y_frac), longint'(ey));
        chk(busy == 1'b0, "R9 idle at done", longint'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 single-cycle done", longint'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0]  lanes_set [3] = '{3'd1, 3'd2, 3'd4};
        logic [19:0] rate_set  [3] = '{20'd162000, 20'd270000, 20'd540000};
        logic [19:0] pclk_set  [2] = '{20'd25175, 20'd148500};
        logic [11:0] pbn_set   [2] = '{12'd200, 12'd700};
        logic [33:0] dsc_f = 34'h1_07AE_147B;
        logic [33:0] fec_f = 34'h1_0624_DD2F;
        logic [34:0] ex, hx;
        logic [8:0]  ey, hy;
        bit got;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(busy == 1'b0, "R12 busy", longint'(busy), 0);
        chk(done == 1'b0, "R12 done", longint'(done), 0);
        chk(x_int == '0, "R12 x_int", longint'(x_int), 0);
        chk(y_frac == '0, "R12 y_frac", longint'(y_frac), 0);

        // Sweep: R4 overhead modes (bit0 = dsc, bit1 = fec), R5 compression
        foreach (lanes_set[li])
            foreach (rate_set[ri])
                foreach (pclk_set[pi])
                    foreach (pbn_set[bi])
                        for (int m = 0; m < 8; m++)
                            run_one(pclk_set[pi], rate_set[ri], lanes_set[li], m[2],
                                    pbn_set[bi], m[0] ? dsc_f : 34'd0,
                                    m[1] ? fec_f : 34'd0);

        // R11: start while busy is ignored
        model(20'd148500, 20'd270000, 3'd4, 6'd24, 1'b0, 6'd8, 12'd700, dsc_f, 34'd0, ex, ey);
        drive(20'd148500, 20'd270000, 3'd4, 1'b0, 12'd700, dsc_f, 34'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        drive(20'd25175, 20'd162000, 3'd1, 1'b1, 12'd200, 34'd0, fec_f);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(got);
        chk(x_int == ex, "R11 x_int after mid-run start", longint'(x_int), longint'(ex));
        chk(y_frac == ey, "R11 y_frac after mid-run start", longint'(y_frac), longint'(ey));
        @(negedge clk);
        chk(busy == 1'b0, "R11 no second run", longint'(busy), 0);

        // R10: results hold while inputs change and no start is given
        hx = x_int;
        hy = y_frac;
        drive(20'd99999, 20'd540000, 3'd2, 1'b1, 12'd999, dsc_f, fec_f);
        repeat (20) @(negedge clk);
        chk(x_int == hx, "R10 x_int held", longint'(x_int), longint'(hx));
        chk(y_frac == hy, "R10 y_frac held", longint'(y_frac), longint'(hy));
        chk(done == 1'b0, "R10 no spurious done", longint'(done), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule